// File: doc/BRIEF.md
# ADC Sample FIFO with DMA Request

This block sits between an ADC conversion sequencer and a bus reader. Each conversion result arrives as a 12-bit value with a 3-bit input number. The block formats it into a 16-bit half-word and stores 32-bit words in a small first-in first-out store. In unpacked mode every sample fills one word. In packed mode two consecutive samples share a word, and that word only becomes readable once its second half is present.

A programmable fill level drives a full flag and a DMA request. The request rises once the stored word count reaches the level. It falls as soon as reads bring the count back under the level, so every new fill produces a fresh request edge. The read port is show-ahead: the oldest word is always presented, and a read strobe pops it. A flush command discards every stored word, any half-filled packing word and the overflow indication. Samples that arrive when the store holds its full capacity are dropped and set a sticky overflow flag.

Top module: `adc_sample_fifo`

## Requirements
- R1: In unpacked mode each accepted sample produces one stored word: bits [11:0] hold the sample value, bits [14:12] the channel field, and bits [31:15] are zero.
- R2: In packed mode the first accepted sample of a pair fills bits [15:0] and the second fills bits [31:16], each half in the R1 half-word layout. A word is stored only when its second half arrives.
- R3: When tagging is enabled the channel field carries the sample's 3-bit channel number. When tagging is disabled the field is zero.
- R4: Words leave in arrival order. `rd_data` shows the oldest stored word, and each `rd_en` cycle on a non-empty store removes exactly one word. A read and a sample in the same cycle both take effect.
- R5: `empty` is high exactly when no word is stored, and `full` and `empty` are never high together.
- R6: `full` and `dma_req` are high exactly when the stored count is at least the effective level. The effective level is `cfg_level` limited to the range 1 to DEPTH (16 by default), so 0 acts as 1 and values above DEPTH act as DEPTH.
- R7: A read while empty returns zero on `rd_data` and changes no state.
- R8: A sample arriving while DEPTH words are stored is dropped, with or without a read in that cycle, and sets `overflow`. `overflow` stays set until flush or reset.
- R9: `flush` empties the store, discards a pending packed half and clears `overflow`. It takes priority over a read or a sample in the same cycle.
- R10: After reset `empty` is 1, `full`, `dma_req` and `overflow` are 0, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_packed | input | 1 | 1 = two samples per word |
| cfg_tag_en | input | 1 | 1 = insert channel number into each half-word |
| cfg_level | input | 5 | Fill level for full flag and DMA request |
| flush | input | 1 | Discard all contents and clear overflow |
| smp_valid | input | 1 | Sample strobe |
| smp_value | input | 12 | Conversion result |
| smp_chan | input | 3 | Input number of the conversion |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest stored word, zero when empty |
| empty | output | 1 | No word stored |
| full | output | 1 | Count at or above effective level |
| dma_req | output | 1 | Transfer request to the DMA engine |
| overflow | output | 1 | Sticky dropped-sample indication |

## Verification
The bench builds the block with its default depth of 16 and a 5-bit level port. This depth is small enough that plain sample streams quickly reach the capacity limit and the overflow drop. The 5-bit level port can carry 0 and values above 16, so both ends of the level clamp are driven directly. Directed phases cover unpacked and packed formatting with tagging on and off, a flush during a half-filled word, and reads on an empty store. A long random phase then mixes reads, samples and occasional flushes across all four mode combinations and several levels.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;

    localparam int SAMPLE_W = 12;
    localparam int CHAN_W   = 3;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;

    typedef struct packed {
        logic                pad;
        logic [CHAN_W-1:0]   chan;
        logic [SAMPLE_W-1:0] value;
    } half_t;

    typedef logic [WORD_W-1:0] word_t;

    function automatic half_t make_half(input logic [SAMPLE_W-1:0] value,
                                        input logic [CHAN_W-1:0]   chan,
                                        input logic                tag_en);
        half_t h;
        h.pad   = 1'b0;
        h.chan  = tag_en ? chan : '0;
        h.value = value;
        return h;
    endfunction

endpackage

// File: rtl/afifo_packer.sv
module afifo_packer
    import adc_fifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                packed_mode,
    input  logic                tag_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_value,
    input  logic [CHAN_W-1:0]   smp_chan,
    input  logic                accept,
    output logic                push,
    output word_t               push_word
);
    half_t half_now;
    half_t pend_half_q;
    logic  pend_q;
    logic  take;

    assign half_now = make_half(smp_value, smp_chan, tag_en);
    assign take     = smp_valid && accept && !flush;

    always_comb begin
        push      = 1'b0;
        push_word = {{HALF_W{1'b0}}, half_now};
        if (take) begin
            if (!packed_mode) begin
                push = 1'b1;
            end else if (pend_q) begin
                push      = 1'b1;
                push_word = {half_now, pend_half_q};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q      <= 1'b0;
            pend_half_q <= '0;
        end else if (take && packed_mode) begin
            pend_q <= !pend_q;
            if (!pend_q) pend_half_q <= half_now;
        end
    end

    // R2
    packed_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (packed_mode && push) |-> pend_q);

endmodule

// File: rtl/afifo_store.sv
module afifo_store
    import adc_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr,
    input  word_t            wr_word,
    input  logic             rd,
    output word_t            head,
    output logic [CNT_W-1:0] count
);
    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_wr, do_rd;

    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    assign do_wr = wr && (count != CAP);
    assign do_rd = rd && (count != '0);
    assign head  = (count == '0) ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr && !rst && !flush) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && count == '0 && !wr && !flush) |=> (count == '0));

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_packed,
    input  logic                cfg_tag_en,
    input  logic [CNT_W-1:0]    cfg_level,
    input  logic                flush,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_value,
    input  logic [CHAN_W-1:0]   smp_chan,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                empty,
    output logic                full,
    output logic                dma_req,
    output logic                overflow
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic             push;
    word_t            push_word;
    word_t            head;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] eff_level;
    logic             store_full;
    logic             ovf_q;

    assign store_full = (count == CAP);

    afifo_packer u_packer (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .packed_mode(cfg_packed),
        .tag_en     (cfg_tag_en),
        .smp_valid  (smp_valid),
        .smp_value  (smp_value),
        .smp_chan   (smp_chan),
        .accept     (!store_full),
        .push       (push),
        .push_word  (push_word)
    );

    afifo_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr     (push),
        .wr_word(push_word),
        .rd     (rd_en && !flush),
        .head   (head),
        .count  (count)
    );

    always_comb begin
        if (cfg_level == '0)     eff_level = CNT_W'(1);
        else if (cfg_level > CAP) eff_level = CAP;
        else                      eff_level = cfg_level;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)                 ovf_q <= 1'b0;
        else if (smp_valid && store_full) ovf_q <= 1'b1;
    end

    assign rd_data  = head;
    assign empty    = (count == '0);
    assign full     = (count >= eff_level);
    assign dma_req  = full;
    assign overflow = ovf_q;

    // R5
    not_full_and_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flush) |=> overflow);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !overflow));

    // R7
    empty_data_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (rd_data == '0));

endmodule

// File: tb/adc_sample_fifo_test.sv
`timescale 1ns/1ps
module adc_sample_fifo_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_packed = 1'b0, cfg_tag_en = 1'b0;
    logic [4:0]  cfg_level = 5'd8;
    logic        flush = 1'b0, smp_valid = 1'b0, rd_en = 1'b0;
    logic [11:0] smp_value = '0;
    logic [2:0]  smp_chan = '0;
    logic [31:0] rd_data;
    logic        empty, full, dma_req, overflow;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R10";

    logic [31:0] q[$];
    bit          m_pend = 0;
    logic [15:0] m_half = '0;
    bit          m_ovf = 0;

    always #2 clk = ~clk;

    adc_sample_fifo uut (
        .clk(clk), .rst(rst), .cfg_packed(cfg_packed), .cfg_tag_en(cfg_tag_en),
        .cfg_level(cfg_level), .flush(flush), .smp_valid(smp_valid),
        .smp_value(smp_value), .smp_chan(smp_chan), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .full(full), .dma_req(dma_req),
        .overflow(overflow)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int eff_lvl();
        if (cfg_level == 0) return 1;
        if (cfg_level > 16) return 16;
        return int'(cfg_level);
    endfunction

    task automatic compare();
        int n = q.size();
        check(tag, "rd_data", rd_data, n > 0 ? q[0] : 32'h0);
        check("R5", "empty", 32'(empty), 32'(n == 0));
        check("R6", "full", 32'(full), 32'(n >= eff_lvl()));
        check("R6", "dma_req", 32'(dma_req), 32'(n >= eff_lvl()));
        check("R8", "overflow", 32'(overflow), 32'(m_ovf));
    endtask

    // Apply current inputs to the model (next state after the coming edge).
    task automatic model_step();
        logic [15:0] h;
        bit was_full;
        if (flush) begin
            q.delete(); m_pend = 0; m_half = '0; m_ovf = 0;
            return;
        end
        was_full = (q.size() == 16);
        if (rd_en && q.size() > 0) void'(q.pop_front());
        if (smp_valid) begin
            if (was_full) m_ovf = 1;
            else begin
                h = {1'b0, cfg_tag_en ? smp_chan : 3'b0, smp_value};
                if (!cfg_packed) q.push_back({16'h0, h});
                else if (!m_pend) begin m_pend = 1; m_half = h; end
                else begin q.push_back({h, m_half}); m_pend = 0; end
            end
        end
    endtask

    task automatic cyc(input bit v, input logic [11:0] d, input logic [2:0] c,
                       input bit rd, input bit fl);
        smp_valid = v; smp_value = d; smp_chan = c; rd_en = rd; flush = fl;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R10";
        compare();

        // R1: unpacked, untagged, level 8
        tag = "R1";
        for (int i = 0; i < 10; i++) cyc(1, 12'h100 + 12'(i * 37), 3'(i), 0, 0);
        // R4: drain in order with some concurrent writes
        tag = "R4";
        for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 12'hA00 + 12'(i), 3'd5, 1, 0);
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0);
        // R7: reads on empty
        tag = "R7";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);
        // R3: tagging enabled
        tag = "R3";
        cfg_tag_en = 1;
        for (int i = 0; i < 8; i++) cyc(1, 12'hFFF - 12'(i), 3'(7 - i), 0, 0);
        for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1, 0);
        // R2: packed mode, tagged and untagged
        tag = "R2";
        cfg_packed = 1;
        for (int i = 0; i < 9; i++) cyc(1, 12'h321 + 12'(i), 3'(i), 0, 0);
        cfg_tag_en = 0;
        for (int i = 0; i < 5; i++) cyc(1, 12'h0F0 + 12'(i), 3'd6, i == 2, 0);
        // R9: flush while half pending, and flush beating read and write
        tag = "R9";
        cyc(1, 12'h777, 3'd1, 1, 1);
        cyc(1, 12'h055, 3'd2, 0, 0);
        cyc(1, 12'h066, 3'd3, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
        // R8: overflow in unpacked mode, with a read in the dropping cycle
        tag = "R8";
        cfg_packed = 0;
        for (int i = 0; i < 20; i++) cyc(1, 12'(i), 3'(i), i == 18, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1);
        // R6: level clamp at 0 and above depth
        tag = "R6";
        cfg_level = 5'd0;
        for (int i = 0; i < 3; i++) cyc(1, 12'h200, 3'd0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
        cfg_level = 5'd31;
        for (int i = 0; i < 17; i++) cyc(1, 12'h300 + 12'(i), 3'd4, 0, 0);
        for (int i = 0; i < 2; i++) cyc(0, 0, 0, 1, 0);
        cfg_level = 5'd16;
        for (int i = 0; i < 3; i++) cyc(1, 12'h3AA, 3'd2, 0, 0);
        cyc(0, 0, 0, 0, 1);

        // Mixed random traffic across modes (R4)
        tag = "R4";
        for (int m = 0; m < 8; m++) begin
            cfg_packed = m[0];
            cfg_tag_en = m[1];
            cfg_level  = 5'($urandom_range(0, 20));
            cyc(0, 0, 0, 0, 1);
            for (int i = 0; i < 500; i++)
                cyc($urandom_range(0, 99) < 55, 12'($urandom), 3'($urandom),
                    $urandom_range(0, 99) < (m[2] ? 25 : 45),
                    $urandom_range(0, 199) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule